// File: doc/BRIEF.md
# Transmit descriptor ring walker

This block is the fetch half of a transmit DMA. Host software lays out a ring of 32-byte descriptors in memory. Each descriptor names one data buffer and carries an ownership flag, an end-of-frame flag and a wrap-to-start flag. A one-cycle poll strobe starts a walk at the current descriptor pointer. The walker reads the descriptor through a single-word memory port and checks that it is well formed. It then streams the buffer's bytes out on a byte-wide valid/ready stream, returns the descriptor to software by clearing its ownership flag, and moves on to the next descriptor.

The walk runs descriptor after descriptor. It ends quietly, with no error indication, at the first descriptor that software still owns or that fails a size check. A one-cycle completion pulse marks every finished frame, so a status block outside can set its transmit-done and normal-summary flags from it. Framing, CRC and the register bank sit outside this block: it takes the ring base and a load strobe as plain inputs, and it shows its current pointer as an output.

Top module: `txring_walker`

## Requirements
- R1: While reset is held and afterwards until the first poll, the walker is idle: busy low, no memory request, no stream beat, no completion pulse, and the current pointer is zero.
- R2: A base-load strobe seen while idle copies the ring base input into the current pointer. The same strobe given while a walk is in progress has no effect.
- R3: On a poll the walker reads word 0 (control) at the current pointer. If control bit 31 (hardware-owned) is clear, the walk ends with nothing streamed, nothing written and the pointer unchanged.
- R4: For an owned descriptor, the buffer length is bits 11:0 of word 1; bits 15:12 are ignored. The buffer address is word 2, with its low two bits ignored. Exactly that many bytes are streamed, in address order, taken from consecutive words in little-endian order (the byte at the lowest address is in bits 7:0).
- R5: The stream's last flag is high on the final byte of a buffer whose control bit 29 (end of frame) is set, and low on every other byte.
- R6: The completion output pulses for exactly one cycle for each processed buffer with control bit 29 set.
- R7: Each processed descriptor is written back as a single write of word 0 at the descriptor's own address, with bit 31 cleared and every other bit kept. No other memory word is written.
- R8: After a writeback, the current pointer reloads from the ring base if control bit 21 (wrap) is set. Otherwise it advances by 32.
- R9: If the buffer length exceeds 2048, or the second-buffer length (bits 27:16 of word 1) is non-zero, the walk ends with no byte streamed, no writeback and the pointer unchanged. A length of exactly 2048 is accepted.
- R10: If the bytes accumulated in the current frame plus this buffer's length reach 8192 or more, the walk ends as in R9. The accumulated count returns to zero after each end-of-frame buffer and at the start of each walk.
- R11: A walk continues until it reaches a descriptor that ends it. A poll that arrives during a walk is held and starts one further walk once the walker has returned to idle. A memory request stays high with a stable address until it is acknowledged.
- R12: While a stream beat is valid and not accepted, its data and last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | One-cycle poll demand |
| base_load_i | input | 1 | Copy ring base into current pointer (idle only) |
| ring_base_i | input | AW | Ring start address |
| cur_ptr_o | output | AW | Current descriptor address |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse per completed frame |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata_i | input | DW | Read data |
| tx_tvalid_o | output | 1 | Stream byte valid |
| tx_tready_i | input | 1 | Stream byte accepted |
| tx_tdata_o | output | 8 | Stream byte |
| tx_tlast_o | output | 1 | Final byte of a frame |

## Verification
The walker is driven through single-buffer frames whose lengths are not multiples of four and whose buffer addresses are unaligned. Stored junk in the upper size bits shows whether the byte count, lane order and alignment masking are right. A three-buffer frame that ends on a wrap descriptor separates where the last flag falls, and whether the wrap reloads the pointer or adds to it. Lengths of 2048 and 2049, a non-zero second length, and a run of buffers reaching 8192 followed by a fresh poll tell the accepted case from each halt. They also show whether the accumulated count is cleared. A repeated poll with a mid-walk base-load strobe shows the held request and the ignored load. A pseudo-random ready pattern on the stream exposes any beat that changes while stalled.

// File: rtl/txr_pkg.sv
package txr_pkg;

   // memory word and descriptor geometry
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned DESC_BYTES = 32;

   // control word flags
   localparam int unsigned OWN_BIT  = 31;
   localparam int unsigned LAST_BIT = 29;
   localparam int unsigned WRAP_BIT = 21;

   // size word: two packed 16-bit halves
   localparam int unsigned LEN1_LO = 0;
   localparam int unsigned LEN2_LO = 16;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_CTL,
      S_RD_SIZE,
      S_RD_BUF,
      S_CHECK,
      S_RD_DATA,
      S_DRAIN,
      S_WB
   } walk_state_e;

endpackage

// File: rtl/txr_desc_check.sv
module txr_desc_check #(
   parameter int unsigned LEN_BITS      = 12,
   parameter int unsigned MAX_BUF_LEN   = 2048,
   parameter int unsigned MAX_FRAME_LEN = 8192,
   parameter int unsigned FRAME_W       = 14
) (
   input  logic [LEN_BITS-1:0] len1_i,
   input  logic [LEN_BITS-1:0] len2_i,
   input  logic [FRAME_W-1:0]  acc_i,
   output logic                ok_o
);

   localparam int unsigned SW = FRAME_W + 1;
   localparam logic [LEN_BITS-1:0] BUF_LIM   = LEN_BITS'(MAX_BUF_LEN);
   localparam logic [SW-1:0]       FRAME_LIM = SW'(MAX_FRAME_LEN);

   logic [SW-1:0] sum;
   logic          len1_ok, len2_ok, frame_ok;

   always_comb begin
      sum      = {1'b0, acc_i} + SW'(len1_i);
      len1_ok  = (len1_i <= BUF_LIM);
      len2_ok  = (len2_i == '0);
      frame_ok = (sum < FRAME_LIM);
      ok_o     = len1_ok && len2_ok && frame_ok;
   end

endmodule

// File: rtl/txr_byte_unpack.sv
module txr_byte_unpack #(
   parameter int unsigned DW = 32,
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] word_i,
   input  logic [CW-1:0] nbytes_i,
   input  logic          last_i,
   output logic          empty_o,
   output logic          tvalid_o,
   input  logic          tready_i,
   output logic [7:0]    tdata_o,
   output logic          tlast_o
);

   localparam int unsigned NB = DW / 8;
   localparam int unsigned IW = $clog2(NB);

   logic [DW-1:0] word_q;
   logic [CW-1:0] cnt_q;
   logic [IW-1:0] idx_q;
   logic          last_q;
   logic [7:0]    lane_w [NB];
   logic          fire;

   // one lane per byte of the staged word, lowest address first
   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_w[g] = word_q[8*g +: 8];
   end

   assign tvalid_o = (cnt_q != '0);
   assign empty_o  = (cnt_q == '0);
   assign tdata_o  = lane_w[idx_q];
   assign tlast_o  = last_q && (cnt_q == CW'(1));
   assign fire     = tvalid_o && tready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         cnt_q  <= '0;
         idx_q  <= '0;
         last_q <= 1'b0;
      end else if (load_i) begin
         word_q <= word_i;
         cnt_q  <= nbytes_i;
         idx_q  <= '0;
         last_q <= last_i;
      end else if (fire) begin
         cnt_q <= cnt_q - CW'(1);
         idx_q <= idx_q + IW'(1);
      end
   end

endmodule

// File: rtl/txr_walk_ctl.sv
module txr_walk_ctl
   import txr_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned LEN_BITS = 12,
   parameter int unsigned FRAME_W  = 14,
   parameter int unsigned CW       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                poll_i,
   input  logic                base_load_i,
   input  logic [AW-1:0]       ring_base_i,
   output logic [AW-1:0]       cur_ptr_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [AW-1:0]       mem_addr_o,
   output logic [DW-1:0]       mem_wdata_o,
   input  logic                mem_ack_i,
   input  logic [DW-1:0]       mem_rdata_i,
   output logic [LEN_BITS-1:0] len1_o,
   output logic [LEN_BITS-1:0] len2_o,
   output logic [FRAME_W-1:0]  acc_o,
   input  logic                ok_i,
   output logic                unpack_load_o,
   output logic [DW-1:0]       unpack_word_o,
   output logic [CW-1:0]       unpack_n_o,
   output logic                unpack_last_o,
   input  logic                unpack_empty_i
);

   localparam logic [AW-1:0]       STEP_WORD  = AW'(WORD_BYTES);
   localparam logic [AW-1:0]       STEP_DESC  = AW'(DESC_BYTES);
   localparam logic [AW-1:0]       ALIGN_MASK = ~AW'(WORD_BYTES - 1);
   localparam logic [LEN_BITS-1:0] NB_L       = LEN_BITS'(WORD_BYTES);
   localparam logic [DW-1:0]       OWN_MASK   = ~(DW'(1) << OWN_BIT);

   walk_state_e         st_q;
   logic [AW-1:0]       cur_q, buf_q, waddr_q;
   logic [DW-1:0]       ctl_q;
   logic [LEN_BITS-1:0] len1_q, len2_q, remain_q, chunk;
   logic [FRAME_W-1:0]  acc_q;
   logic                pend_q, done_q;
   logic                mem_fire, is_last, is_wrap;

   assign mem_fire = mem_req_o && mem_ack_i;
   assign is_last  = ctl_q[LAST_BIT];
   assign is_wrap  = ctl_q[WRAP_BIT];
   assign chunk    = (remain_q >= NB_L) ? NB_L : remain_q;

   assign cur_ptr_o     = cur_q;
   assign busy_o        = (st_q != S_IDLE);
   assign done_o        = done_q;
   assign len1_o        = len1_q;
   assign len2_o        = len2_q;
   assign acc_o         = acc_q;
   assign unpack_load_o = (st_q == S_RD_DATA) && mem_fire;
   assign unpack_word_o = mem_rdata_i;
   assign unpack_n_o    = chunk[CW-1:0];
   assign unpack_last_o = is_last && (remain_q <= NB_L);
   assign mem_wdata_o   = ctl_q & OWN_MASK;

   always_comb begin
      mem_req_o  = 1'b0;
      mem_we_o   = 1'b0;
      mem_addr_o = cur_q;
      unique case (st_q)
         S_RD_CTL:  mem_req_o = 1'b1;
         S_RD_SIZE: begin
            mem_req_o  = 1'b1;
            mem_addr_o = cur_q + STEP_WORD;
         end
         S_RD_BUF:  begin
            mem_req_o  = 1'b1;
            mem_addr_o = cur_q + (STEP_WORD << 1);
         end
         S_RD_DATA: begin
            mem_req_o  = 1'b1;
            mem_addr_o = waddr_q;
         end
         S_WB:      begin
            mem_req_o = 1'b1;
            mem_we_o  = 1'b1;
         end
         default:   ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         cur_q    <= '0;
         buf_q    <= '0;
         waddr_q  <= '0;
         ctl_q    <= '0;
         len1_q   <= '0;
         len2_q   <= '0;
         remain_q <= '0;
         acc_q    <= '0;
         pend_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (poll_i && (st_q != S_IDLE)) pend_q <= 1'b1;
         unique case (st_q)
            S_IDLE: begin
               if (base_load_i) cur_q <= ring_base_i;
               if (poll_i || pend_q) begin
                  pend_q <= 1'b0;
                  acc_q  <= '0;
                  st_q   <= S_RD_CTL;
               end
            end
            S_RD_CTL: if (mem_fire) begin
               ctl_q <= mem_rdata_i;
               st_q  <= mem_rdata_i[OWN_BIT] ? S_RD_SIZE : S_IDLE;
            end
            S_RD_SIZE: if (mem_fire) begin
               len1_q <= mem_rdata_i[LEN1_LO +: LEN_BITS];
               len2_q <= mem_rdata_i[LEN2_LO +: LEN_BITS];
               st_q   <= S_RD_BUF;
            end
            S_RD_BUF: if (mem_fire) begin
               buf_q <= mem_rdata_i[AW-1:0] & ALIGN_MASK;
               st_q  <= S_CHECK;
            end
            S_CHECK: begin
               if (!ok_i) begin
                  st_q <= S_IDLE;
               end else begin
                  remain_q <= len1_q;
                  waddr_q  <= buf_q;
                  acc_q    <= is_last ? '0 : acc_q + FRAME_W'(len1_q);
                  st_q     <= (len1_q == '0) ? S_WB : S_RD_DATA;
               end
            end
            S_RD_DATA: if (mem_fire) begin
               remain_q <= remain_q - chunk;
               waddr_q  <= waddr_q + STEP_WORD;
               st_q     <= S_DRAIN;
            end
            S_DRAIN: if (unpack_empty_i) begin
               st_q <= (remain_q == '0) ? S_WB : S_RD_DATA;
            end
            S_WB: if (mem_fire) begin
               done_q <= is_last;
               cur_q  <= is_wrap ? ring_base_i : cur_q + STEP_DESC;
               st_q   <= S_RD_CTL;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
   parameter int unsigned AW            = 32,
   parameter int unsigned DW            = 32,
   parameter int unsigned LEN_BITS      = 12,
   parameter int unsigned MAX_BUF_LEN   = 2048,
   parameter int unsigned MAX_FRAME_LEN = 8192
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          poll_i,
   input  logic          base_load_i,
   input  logic [AW-1:0] ring_base_i,
   output logic [AW-1:0] cur_ptr_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic          mem_ack_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          tx_tvalid_o,
   input  logic          tx_tready_i,
   output logic [7:0]    tx_tdata_o,
   output logic          tx_tlast_o
);

   localparam int unsigned FRAME_W = $clog2(MAX_FRAME_LEN + 1);
   localparam int unsigned CW      = $clog2(DW / 8 + 1);

   // elaboration-time parameter checks
   if (DW != 32) begin : g_bad_dw
      $error("txring_walker: descriptor words are 32 bits wide");
   end
   if (AW > DW || AW < 8) begin : g_bad_aw
      $error("txring_walker: AW must lie between 8 and DW");
   end
   if (MAX_BUF_LEN >= (1 << LEN_BITS)) begin : g_bad_buf
      $error("txring_walker: MAX_BUF_LEN must fit in LEN_BITS");
   end
   if (MAX_FRAME_LEN <= MAX_BUF_LEN) begin : g_bad_frame
      $error("txring_walker: MAX_FRAME_LEN must exceed MAX_BUF_LEN");
   end

   logic [LEN_BITS-1:0] len1, len2;
   logic [FRAME_W-1:0]  acc;
   logic                desc_ok;
   logic                up_load, up_last, up_empty;
   logic [DW-1:0]       up_word;
   logic [CW-1:0]       up_n;

   txr_walk_ctl #(
      .AW(AW), .DW(DW), .LEN_BITS(LEN_BITS), .FRAME_W(FRAME_W), .CW(CW)
   ) u_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .poll_i         (poll_i),
      .base_load_i    (base_load_i),
      .ring_base_i    (ring_base_i),
      .cur_ptr_o      (cur_ptr_o),
      .busy_o         (busy_o),
      .done_o         (done_o),
      .mem_req_o      (mem_req_o),
      .mem_we_o       (mem_we_o),
      .mem_addr_o     (mem_addr_o),
      .mem_wdata_o    (mem_wdata_o),
      .mem_ack_i      (mem_ack_i),
      .mem_rdata_i    (mem_rdata_i),
      .len1_o         (len1),
      .len2_o         (len2),
      .acc_o          (acc),
      .ok_i           (desc_ok),
      .unpack_load_o  (up_load),
      .unpack_word_o  (up_word),
      .unpack_n_o     (up_n),
      .unpack_last_o  (up_last),
      .unpack_empty_i (up_empty)
   );

   txr_desc_check #(
      .LEN_BITS(LEN_BITS), .MAX_BUF_LEN(MAX_BUF_LEN),
      .MAX_FRAME_LEN(MAX_FRAME_LEN), .FRAME_W(FRAME_W)
   ) u_chk_desc (
      .len1_i (len1),
      .len2_i (len2),
      .acc_i  (acc),
      .ok_o   (desc_ok)
   );

   txr_byte_unpack #(
      .DW(DW), .CW(CW)
   ) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (up_load),
      .word_i   (up_word),
      .nbytes_i (up_n),
      .last_i   (up_last),
      .empty_o  (up_empty),
      .tvalid_o (tx_tvalid_o),
      .tready_i (tx_tready_i),
      .tdata_o  (tx_tdata_o),
      .tlast_o  (tx_tlast_o)
   );

endmodule

// File: rtl/txring_walker_chk.sv
module txring_walker_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ring_base_i,
   input logic [AW-1:0] cur_ptr_o,
   input logic          busy_o,
   input logic          done_o,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          wb_own_i,
   input logic          mem_ack_i,
   input logic          tx_tvalid_o,
   input logic          tx_tready_i,
   input logic [7:0]    tx_tdata_o,
   input logic          tx_tlast_o
);

   localparam logic [AW-1:0] DSTEP = AW'(32);

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tvalid_o && !tx_tready_i |=> tx_tvalid_o && $stable(tx_tdata_o) && $stable(tx_tlast_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o && !tx_tvalid_o);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   wb_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> !wb_own_i);

   // R8
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_ptr_o) |-> (cur_ptr_o == $past(cur_ptr_o) + DSTEP) || (cur_ptr_o == $past(ring_base_i)));

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

endmodule

bind txring_walker txring_walker_chk #(.AW(AW)) u_walk_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ring_base_i (ring_base_i),
   .cur_ptr_o   (cur_ptr_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .wb_own_i    (mem_wdata_o[31]),
   .mem_ack_i   (mem_ack_i),
   .tx_tvalid_o (tx_tvalid_o),
   .tx_tready_i (tx_tready_i),
   .tx_tdata_o  (tx_tdata_o),
   .tx_tlast_o  (tx_tlast_o)
);

// File: tb/txring_walker_tb.sv
module txring_walker_tb;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int MEM_WORDS = 4096;
   localparam int WD_LIMIT = 150000;
   localparam logic [31:0] BASE = 32'h0000_1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          poll = 1'b0;
   logic          base_load = 1'b0;
   logic [AW-1:0] ring_base = '0;
   logic [AW-1:0] cur_ptr;
   logic          busy, done;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          tvalid, tready, tlast;
   logic [7:0]    tdata;

   logic [31:0] mem [MEM_WORDS];
   logic [31:0] mm  [MEM_WORDS];
   logic [8:0]  exp_q [$];

   int n_chk = 0, n_fail = 0, cyc = 0;
   int done_seen = 0, busy_rises = 0, beats = 0, mdone = 0;
   logic busy_d = 1'b0;
   logic stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [AW-1:0] mptr = '0;

   always #5 clk = ~clk;

   txring_walker u_dut (
      .clk(clk), .rst_n(rst_n), .poll_i(poll), .base_load_i(base_load),
      .ring_base_i(ring_base), .cur_ptr_o(cur_ptr), .busy_o(busy), .done_o(done),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .tx_tvalid_o(tvalid), .tx_tready_i(tready), .tx_tdata_o(tdata), .tx_tlast_o(tlast)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // memory model: one-cycle registered acknowledge
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
         end
      end
   end

   // stream sink ready pattern
   always @(posedge clk) begin
      lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tready <= stall_en ? lfsr[3] : 1'b1;
   end

   // per-clock comparison against the reference byte queue
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (tvalid && tready) begin
            beats++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "unexpected stream beat", {23'd0, tlast, tdata}, 32'h0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               // R4 data, R5 last flag
               check({tlast, tdata} == e, "R4 R5", "stream beat {last,data}",
                     {23'd0, tlast, tdata}, {23'd0, e});
            end
         end
         if (done) done_seen++;
         if (busy && !busy_d) busy_rises++;
         busy_d <= busy;
         if (cyc > WD_LIMIT) begin
            check(1'b0, "watchdog", "run did not finish", cyc, WD_LIMIT);
            finish_run();
         end
      end
   end

   task automatic wr(input int unsigned a, input logic [31:0] v);
      mem[a >> 2] = v;
      mm[a >> 2]  = v;
   endtask

   task automatic set_desc(input int i, input bit own, input bit last, input bit wrap,
                           input logic [15:0] s1, input logic [15:0] s2,
                           input logic [31:0] baddr);
      int unsigned a;
      a = BASE + 32 * i;
      wr(a,      {own, 1'b0, last, 7'd0, wrap, 13'd0, 8'(i) ^ 8'h40});
      wr(a + 4,  {s2, s1});
      wr(a + 8,  baddr);
      for (int k = 3; k < 8; k++) wr(a + 4 * k, 32'hD0D0_0000 | (i << 4) | k);
   endtask

   // behavioural reference of one walk, applied to the model memory
   task automatic model_walk();
      int acc = 0;
      for (int guard = 0; guard < 1000; guard++) begin
         int unsigned w, l1, l2, ba;
         logic [31:0] ctl;
         w   = mptr >> 2;
         ctl = mm[w];
         if (!ctl[31]) break;
         l1 = mm[w + 1][11:0];
         l2 = mm[w + 1][27:16];
         if (l1 > 2048 || l2 != 0 || acc + l1 >= 8192) break;
         ba = mm[w + 2] & 32'hFFFF_FFFC;
         for (int unsigned i = 0; i < l1; i++) begin
            int unsigned a;
            logic [31:0] word;
            a = ba + i;
            word = mm[a >> 2];
            exp_q.push_back({ctl[29] && (i == l1 - 1), word[8 * (a % 4) +: 8]});
         end
         acc += l1;
         if (ctl[29]) begin
            acc = 0;
            mdone++;
         end
         mm[w] = ctl & 32'h7FFF_FFFF;
         mptr = ctl[21] ? ring_base : mptr + 32;
      end
   endtask

   task automatic wait_idle();
      int quiet = 0;
      while (quiet < 4) begin
         @(negedge clk);
         quiet = busy ? 0 : quiet + 1;
      end
   endtask

   task automatic pulse_poll();
      @(negedge clk) poll = 1'b1;
      @(negedge clk) poll = 1'b0;
   endtask

   task automatic load_base(input logic [31:0] b);
      @(negedge clk);
      ring_base = b;
      base_load = 1'b1;
      @(negedge clk) base_load = 1'b0;
      mptr = b;
   endtask

   task automatic compare_all(input string tag);
      int bad = 0;
      for (int w = 0; w < MEM_WORDS; w++) if (mem[w] !== mm[w]) bad++;
      // R7: only word 0 of processed descriptors may change
      check(bad == 0, "R7", {tag, " memory image"}, bad, 0);
      // R6
      check(done_seen == mdone, "R6", {tag, " completion pulses"}, done_seen, mdone);
      // R8
      check(cur_ptr == mptr, "R8", {tag, " current pointer"}, cur_ptr, mptr);
      // R4
      check(exp_q.size() == 0, "R4", {tag, " bytes left unsent"}, exp_q.size(), 0);
   endtask

   task automatic run_walk(input string tag);
      model_walk();
      pulse_poll();
      wait_idle();
      compare_all(tag);
   endtask

   initial begin
      int b0;
      int rises0;
      for (int w = 0; w < MEM_WORDS; w++) begin
         mem[w] = (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
         mm[w]  = mem[w];
      end
      for (int i = 0; i < 16; i++) set_desc(i, 1'b0, 1'b0, 1'b0, 16'd4, 16'd0, 32'h2000);

      repeat (3) @(negedge clk);
      // R1: idle state under reset
      check(!busy && !tvalid && !mem_req && !done, "R1", "outputs under reset",
            {busy, tvalid, mem_req, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cur_ptr == 0 && !busy && !mem_req, "R1", "state after reset",
            cur_ptr, 0);

      // R2: base load while idle
      load_base(BASE);
      check(cur_ptr == BASE, "R2", "pointer after base load", cur_ptr, BASE);

      // R3: unowned descriptor stops at once
      b0 = beats;
      run_walk("R3 unowned");
      check(beats == b0, "R3", "beats on unowned descriptor", beats, b0);

      // R4 R5: three single-buffer frames, odd lengths and unaligned addresses
      stall_en = 1'b1;
      set_desc(0, 1'b1, 1'b1, 1'b0, 16'hF005, 16'h0000, 32'h0000_2001);
      set_desc(1, 1'b1, 1'b1, 1'b0, 16'd8,    16'h0000, 32'h0000_2100);
      set_desc(2, 1'b1, 1'b1, 1'b0, 16'd1,    16'hF000, 32'h0000_2203);
      run_walk("R4 single frames");

      // R5 R8: three-buffer frame ending on a wrap descriptor
      set_desc(3, 1'b1, 1'b0, 1'b0, 16'd7, 16'd0, 32'h0000_2300);
      set_desc(4, 1'b1, 1'b0, 1'b0, 16'd4, 16'd0, 32'h0000_2402);
      set_desc(5, 1'b1, 1'b1, 1'b1, 16'd2, 16'd0, 32'h0000_2500);
      run_walk("R5 R8 multi-buffer wrap");
      check(cur_ptr == BASE, "R8", "pointer wrapped to base", cur_ptr, BASE);

      // R9: oversize buffer and non-zero second length halt silently
      set_desc(0, 1'b1, 1'b1, 1'b0, 16'd2049, 16'd0, 32'h0000_2000);
      b0 = beats;
      run_walk("R9 length 2049");
      check(beats == b0 && cur_ptr == BASE, "R9", "halt on length 2049", cur_ptr, BASE);
      set_desc(0, 1'b1, 1'b1, 1'b0, 16'd5, 16'd3, 32'h0000_2000);
      run_walk("R9 second buffer");
      check(beats == b0 && cur_ptr == BASE, "R9", "halt on second length", cur_ptr, BASE);
      set_desc(0, 1'b1, 1'b1, 1'b0, 16'd2048, 16'd0, 32'h0000_2000);
      run_walk("R9 length 2048");
      check(cur_ptr == BASE + 32, "R9", "length 2048 accepted", cur_ptr, BASE + 32);

      // R10: accumulated length reaching 8192 halts; new walk starts from zero
      load_base(BASE);
      for (int i = 0; i < 4; i++) set_desc(i, 1'b1, 1'b0, 1'b0, 16'd2048, 16'd0, 32'h0000_2000);
      set_desc(4, 1'b1, 1'b1, 1'b0, 16'd1, 16'd0, 32'h0000_2000);
      set_desc(5, 1'b0, 1'b0, 1'b0, 16'd1, 16'd0, 32'h0000_2000);
      run_walk("R10 frame limit");
      check(cur_ptr == BASE + 96, "R10", "halt at 8192 accumulated", cur_ptr, BASE + 96);
      run_walk("R10 restart");
      check(cur_ptr == BASE + 160, "R10", "count cleared on new walk", cur_ptr, BASE + 160);

      // R11 R2: poll held during a walk; base load during a walk ignored
      load_base(BASE);
      set_desc(0, 1'b1, 1'b1, 1'b0, 16'd40, 16'd0, 32'h0000_2600);
      set_desc(1, 1'b1, 1'b1, 1'b0, 16'd3,  16'd0, 32'h0000_2700);
      set_desc(2, 1'b0, 1'b0, 1'b0, 16'd3,  16'd0, 32'h0000_2700);
      model_walk();
      model_walk();
      rises0 = busy_rises;
      pulse_poll();
      repeat (3) @(negedge clk);
      poll = 1'b1;
      base_load = 1'b1;
      ring_base = 32'h0000_1800;
      @(negedge clk);
      poll = 1'b0;
      base_load = 1'b0;
      ring_base = BASE;
      wait_idle();
      check(busy_rises - rises0 == 2, "R11", "walks started by two polls",
            busy_rises - rises0, 2);
      check(cur_ptr == BASE + 64, "R2", "base load ignored while busy", cur_ptr, BASE + 64);
      compare_all("R11 pending poll");

      finish_run();
   end

endmodule